// File: doc/BRIEF.md
# Boot Configuration Sequencer for a Two-Channel Receiver

This block brings up two receiver channels after reset. It uses a register-access master port, where each access is one 32-bit word addressed by channel and register number. First it writes a built-in table of factory values to all 22 registers (2 channels, 11 registers each). Next it reads a stored-settings image through a byte-wide memory port that uses request and acknowledge. If the 4-byte header at the start of that image holds the expected magic word, the block loads every register again with the stored word.

After configuration, a fixed settle interval runs. At its end, a stream-enable output rises and stays high. Once the block reports done, a save command writes the magic header and then every register value into the same image. Each value is first read back from the receiver.

All multi-byte words travel least significant byte first, at increasing byte addresses. The stored image is ordered by channel first, then by register. Register word `w = ch*11 + reg` sits at byte address `0x3F04 + 4*w`.

Top module: `cfgseq_top`

## Requirements
- R1: While reset is held, status is 0 (idle), stream_en is 0 and neither port requests. On the first clock after reset is released, status becomes 1.
- R2: Loading the factory values makes 22 register writes: channel 0 registers 0 to 10, then channel 1 registers 0 to 10. Channel 0 register 0 gets 0xA2241797, register 1 gets 0x20550288, register 9 gets 0x00000002 and register 10 gets 0x00000004.
- R3: After the factory writes, four memory reads fetch bytes 0x3F00, 0x3F01, 0x3F02 and 0x3F03, in that order. The byte at 0x3F00 is the least significant byte of the header word.
- R4: If the header word is not 0xABC00CBA, no further memory read and no further register write takes place, and the factory values remain.
- R5: If the header matches, then for each word w in channel-major order the block reads bytes 0x3F04+4w to 0x3F04+4w+3, lowest first. It then writes the assembled word to that channel and register.
- R6: A request stays high with unchanged fields until its acknowledge. Only one port requests at a time. In the cycle after an acknowledge, neither port requests.
- R7: Once configuration ends, status is 3 (settle) for exactly 255 clock cycles. Then stream_en rises together with status 4 (done) and stays high until reset.
- R8: A save_req seen while status is 4 starts a save. The save writes bytes 0xBA, 0x0C, 0xC0, 0xAB to addresses 0x3F00 to 0x3F03. Then, for each word w in order, it reads the register back and writes its four bytes, lowest first, to 0x3F04+4w onward. Status then returns to 4.
- R9: save_req has no effect while status is 1, 2, 3 or 5: no save starts and no memory write appears.
- R10: Status encoding: 0 idle, 1 factory load, 2 stored load, 3 settle, 4 done, 5 saving. The header check itself reports status 2.
- R11: stream_en remains high while a save runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_req | input | 1 | Request to store all registers into the image |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 write, 0 read |
| reg_ch | output | 1 | Channel number |
| reg_addr | output | 4 | Register number 0..10 |
| reg_wdata | output | 32 | Register write word |
| reg_rdata | input | 32 | Register read word, valid with reg_ack |
| reg_ack | input | 1 | Register access complete |
| mem_req | output | 1 | Memory byte access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 14 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |
| stream_en | output | 1 | Sample streaming may run |
| status | output | 3 | Current phase, encoded as in R10 |

## Verification
A wrong cursor or byte index shows up at the very next request on either port, as a wrong channel, register or byte address. A wrong assembly of a word appears as the data of the register write that follows four byte reads, or as a wrong byte value during a save. A wrong header decision shows up within one access: a stored-word read appears when none should, or a settle period starts early. A wrong settle count is visible at the single edge where stream_en rises.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    localparam int NUM_CH  = 2;
    localparam int NUM_REG = 11;
    localparam int CH_W    = 1;
    localparam int RA_W    = 4;
    localparam int MA_W    = 14;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int IDX_W   = $clog2(NUM_CH * NUM_REG);

    // externally visible phase code
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_DEFAULTS = 3'd1,
        ST_STORED   = 3'd2,
        ST_SETTLE   = 3'd3,
        ST_DONE     = 3'd4,
        ST_SAVING   = 3'd5
    } status_e;

    // internal sequencer steps
    typedef enum logic [3:0] {
        P_IDLE,
        P_DEF_WR,
        P_HDR_RD,
        P_STO_RD,
        P_STO_WR,
        P_SETTLE,
        P_DONE,
        P_SV_HDR,
        P_SV_RD,
        P_SV_WR
    } phase_e;

    function automatic status_e status_of(input phase_e p);
        case (p)
            P_IDLE:                     return ST_IDLE;
            P_DEF_WR:                   return ST_DEFAULTS;
            P_HDR_RD, P_STO_RD,
            P_STO_WR:                   return ST_STORED;
            P_SETTLE:                   return ST_SETTLE;
            P_DONE:                     return ST_DONE;
            default:                    return ST_SAVING;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] byte_of(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] sel);
        return w[{sel, 3'b000} +: BYTE_W];
    endfunction

endpackage

// File: rtl/cfgseq_defaults.sv
module cfgseq_defaults
    import cfgseq_pkg::*;
(
    input  logic [CH_W-1:0]   ch,
    input  logic [RA_W-1:0]   ra,
    output logic [WORD_W-1:0] word
);
    logic [IDX_W-1:0] idx;
    assign idx = IDX_W'(int'(ch) * NUM_REG + int'(ra));

    always_comb begin
        case (idx)
            5'd0:  word = 32'hA2241797;
            5'd1:  word = 32'h20550288;
            5'd2:  word = 32'h0E9F21DC;
            5'd3:  word = 32'h69888000;
            5'd4:  word = 32'h00082008;
            5'd5:  word = 32'h0647AE70;
            5'd6:  word = 32'h08000000;
            5'd7:  word = 32'h00000000;
            5'd8:  word = 32'h01E0F281;
            5'd9:  word = 32'h00000002;
            5'd10: word = 32'h00000004;
            5'd11: word = 32'hA224A019;
            5'd12: word = 32'h28550288;
            5'd13: word = 32'h0E9F31DC;
            5'd14: word = 32'h78888000;
            5'd15: word = 32'h00062008;
            5'd16: word = 32'h004CCD70;
            5'd17: word = 32'h08000000;
            5'd18: word = 32'h10000000;
            5'd19: word = 32'h01E0F281;
            5'd20: word = 32'h00000002;
            5'd21: word = 32'h00000004;
            default: word = '0;
        endcase
    end
endmodule

// File: rtl/cfgseq_cursor.sv
module cfgseq_cursor
    import cfgseq_pkg::*;
#(
    parameter int BASE = 16'h3F04
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            byte_step,
    input  logic            word_step,
    output logic [CH_W-1:0] ch,
    output logic [RA_W-1:0] ra,
    output logic [1:0]      bsel,
    output logic            last_byte,
    output logic            last_word,
    output logic [MA_W-1:0] img_addr
);
    localparam logic [CH_W-1:0] CH_LAST = CH_W'(NUM_CH - 1);
    localparam logic [RA_W-1:0] RA_LAST = RA_W'(NUM_REG - 1);

    logic [CH_W-1:0] ch_q;
    logic [RA_W-1:0] ra_q;
    logic [1:0]      b_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ch_q <= '0;
            ra_q <= '0;
            b_q  <= '0;
        end else if (word_step) begin
            b_q <= '0;
            if (ra_q == RA_LAST) begin
                ra_q <= '0;
                ch_q <= ch_q + 1'b1;
            end else begin
                ra_q <= ra_q + 1'b1;
            end
        end else if (byte_step) begin
            b_q <= b_q + 2'd1;
        end
    end

    assign ch        = ch_q;
    assign ra        = ra_q;
    assign bsel      = b_q;
    assign last_byte = (b_q == 2'd3);
    assign last_word = (ch_q == CH_LAST) && (ra_q == RA_LAST);
    assign img_addr  = MA_W'(BASE + 4 * (int'(ch_q) * NUM_REG + int'(ra_q)) + int'(b_q));

    // R5: the register index never leaves the implemented range
    a_r5_reg_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(ra_q) < NUM_REG);
endmodule

// File: rtl/cfgseq_settle.sv
module cfgseq_settle #(
    parameter int UNITS       = 255,
    parameter int UNIT_CYCLES = 1
)(
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire
);
    localparam int TOTAL = UNITS * UNIT_CYCLES;
    localparam int CW    = $clog2(TOTAL + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (cnt_q == CW'(TOTAL - 1));

    // R7: the interval counter never runs past its length
    a_r7_count_bounded: assert property (@(posedge clk) disable iff (rst)
        run |-> int'(cnt_q) < TOTAL);
endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
    import cfgseq_pkg::*;
#(
    parameter int                 HDR_ADDR    = 16'h3F00,
    parameter int                 IMG_ADDR    = 16'h3F04,
    parameter logic [WORD_W-1:0]  MAGIC       = 32'hABC00CBA,
    parameter int                 SETTLE_UNITS = 255,
    parameter int                 UNIT_CYCLES  = 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              save_req,
    output logic              reg_req,
    output logic              reg_we,
    output logic [CH_W-1:0]   reg_ch,
    output logic [RA_W-1:0]   reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata,
    input  logic              reg_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MA_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              stream_en,
    output logic [2:0]        status
);
    phase_e            phase_q, phase_d;
    logic              busy_q;
    logic              stream_q;
    logic [WORD_W-1:0] asm_q;

    logic              cur_clr, cur_byte, cur_word;
    logic [CH_W-1:0]   cur_ch;
    logic [RA_W-1:0]   cur_ra;
    logic [1:0]        cur_b;
    logic              last_byte, last_word;
    logic [MA_W-1:0]   img_addr;
    logic [WORD_W-1:0] def_word;
    logic              settle_exp;
    logic              is_reg, is_mem, acc_done;
    logic [WORD_W-1:0] hdr_word;

    cfgseq_cursor #(.BASE(IMG_ADDR)) u_cursor (
        .clk(clk), .rst(rst), .clr(cur_clr), .byte_step(cur_byte), .word_step(cur_word),
        .ch(cur_ch), .ra(cur_ra), .bsel(cur_b), .last_byte(last_byte),
        .last_word(last_word), .img_addr(img_addr)
    );

    cfgseq_defaults u_defaults (.ch(cur_ch), .ra(cur_ra), .word(def_word));

    cfgseq_settle #(.UNITS(SETTLE_UNITS), .UNIT_CYCLES(UNIT_CYCLES)) u_settle (
        .clk(clk), .rst(rst), .run(phase_q == P_SETTLE), .expire(settle_exp)
    );

    assign is_reg   = phase_q inside {P_DEF_WR, P_STO_WR, P_SV_RD};
    assign is_mem   = phase_q inside {P_HDR_RD, P_STO_RD, P_SV_HDR, P_SV_WR};
    assign acc_done = busy_q && ((is_reg && reg_ack) || (is_mem && mem_ack));
    assign hdr_word = {mem_rdata, asm_q[23:0]};

    always_comb begin
        phase_d  = phase_q;
        cur_clr  = 1'b0;
        cur_byte = 1'b0;
        cur_word = 1'b0;
        case (phase_q)
            P_IDLE:   phase_d = P_DEF_WR;
            P_DEF_WR: if (acc_done) begin
                if (last_word) begin cur_clr = 1'b1; phase_d = P_HDR_RD; end
                else cur_word = 1'b1;
            end
            P_HDR_RD: if (acc_done) begin
                if (last_byte) begin
                    cur_clr = 1'b1;
                    phase_d = (hdr_word == MAGIC) ? P_STO_RD : P_SETTLE;
                end else cur_byte = 1'b1;
            end
            P_STO_RD: if (acc_done) begin
                cur_byte = 1'b1;
                if (last_byte) phase_d = P_STO_WR;
            end
            P_STO_WR: if (acc_done) begin
                if (last_word) begin cur_clr = 1'b1; phase_d = P_SETTLE; end
                else begin cur_word = 1'b1; phase_d = P_STO_RD; end
            end
            P_SETTLE: if (settle_exp) phase_d = P_DONE;
            P_DONE:   if (save_req) begin cur_clr = 1'b1; phase_d = P_SV_HDR; end
            P_SV_HDR: if (acc_done) begin
                cur_byte = 1'b1;
                if (last_byte) phase_d = P_SV_RD;
            end
            P_SV_RD:  if (acc_done) phase_d = P_SV_WR;
            P_SV_WR:  if (acc_done) begin
                if (!last_byte) cur_byte = 1'b1;
                else if (last_word) begin cur_clr = 1'b1; phase_d = P_DONE; end
                else begin cur_word = 1'b1; phase_d = P_SV_RD; end
            end
            default:  phase_d = P_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= P_IDLE;
            busy_q   <= 1'b0;
            stream_q <= 1'b0;
            asm_q    <= '0;
        end else begin
            phase_q <= phase_d;
            if (acc_done)                      busy_q <= 1'b0;
            else if ((is_reg || is_mem) && !busy_q) busy_q <= 1'b1;
            if (acc_done && (phase_q == P_HDR_RD || phase_q == P_STO_RD))
                asm_q[{cur_b, 3'b000} +: BYTE_W] <= mem_rdata;
            if (acc_done && phase_q == P_SV_RD)
                asm_q <= reg_rdata;
            if (phase_q == P_SETTLE && settle_exp)
                stream_q <= 1'b1;
        end
    end

    assign reg_req   = busy_q && is_reg;
    assign reg_we    = (phase_q != P_SV_RD);
    assign reg_ch    = cur_ch;
    assign reg_addr  = cur_ra;
    assign reg_wdata = (phase_q == P_DEF_WR) ? def_word : asm_q;

    assign mem_req   = busy_q && is_mem;
    assign mem_we    = (phase_q == P_SV_HDR) || (phase_q == P_SV_WR);
    assign mem_addr  = (phase_q == P_HDR_RD || phase_q == P_SV_HDR)
                       ? MA_W'(HDR_ADDR + int'(cur_b)) : img_addr;
    assign mem_wdata = (phase_q == P_SV_HDR) ? byte_of(MAGIC, cur_b) : byte_of(asm_q, cur_b);

    assign stream_en = stream_q;
    assign status    = 3'(status_of(phase_q));

    // R1: the idle state issues nothing
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        status == 3'(ST_IDLE) |-> !reg_req && !mem_req && !stream_en);

    // R6: request fields hold until acknowledged
    a_r6_reg_hold: assert property (@(posedge clk) disable iff (rst)
        reg_req && !reg_ack |=> reg_req && $stable(reg_we) && $stable(reg_ch)
                                && $stable(reg_addr) && $stable(reg_wdata));
    a_r6_mem_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                                && $stable(mem_wdata));
    a_r6_one_port: assert property (@(posedge clk) disable iff (rst)
        !(reg_req && mem_req));
    a_r6_gap_reg: assert property (@(posedge clk) disable iff (rst)
        reg_req && reg_ack |=> !reg_req && !mem_req);
    a_r6_gap_mem: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> !reg_req && !mem_req);

    // R7: stream enable rises only out of settle and never falls
    a_r7_stream_sticky: assert property (@(posedge clk) disable iff (rst)
        stream_en |=> stream_en);
    a_r7_stream_rise: assert property (@(posedge clk) disable iff (rst)
        !stream_en ##1 stream_en |-> status == 3'(ST_DONE) && $past(status) == 3'(ST_SETTLE));

    // R8: memory writes happen only while saving
    a_r8_write_only_saving: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> status == 3'(ST_SAVING));

    // R9: a save request during loading is ignored
    a_r9_save_ignored: assert property (@(posedge clk) disable iff (rst)
        save_req && (status inside {3'(ST_DEFAULTS), 3'(ST_STORED), 3'(ST_SETTLE)})
        |=> status != 3'(ST_SAVING));
endmodule

// File: tb/cfgseq_top_tb.sv
module cfgseq_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        save_req = 1'b0;
    logic        reg_req, reg_we;
    logic [0:0]  reg_ch;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;
    logic        reg_ack = 1'b0;
    logic        mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        stream_en;
    logic [2:0]  status;

    always #5 clk = ~clk;

    cfgseq_top u_dut (
        .clk(clk), .rst(rst), .save_req(save_req),
        .reg_req(reg_req), .reg_we(reg_we), .reg_ch(reg_ch), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .stream_en(stream_en), .status(status)
    );

    localparam logic [31:0] DEF [22] = '{
        32'hA2241797, 32'h20550288, 32'h0E9F21DC, 32'h69888000, 32'h00082008, 32'h0647AE70,
        32'h08000000, 32'h00000000, 32'h01E0F281, 32'h00000002, 32'h00000004,
        32'hA224A019, 32'h28550288, 32'h0E9F31DC, 32'h78888000, 32'h00062008, 32'h004CCD70,
        32'h08000000, 32'h10000000, 32'h01E0F281, 32'h00000002, 32'h00000004};
    localparam logic [31:0] MAGIC = 32'hABC00CBA;

    typedef struct {
        int          kind;   // 0 reg write, 1 reg read, 2 mem read, 3 mem write
        int          ch;
        int          ra;
        int          ma;
        logic [31:0] d;
        string       tag;
    } txn_t;

    txn_t        expq[$];
    logic [7:0]  mem [0:16383];
    logic [31:0] rf  [0:21];
    int n_chk = 0, n_fail = 0;
    int ntx = 0, wait_cnt = 0;
    int settle_cnt = 0;
    bit prev_stream = 0, pend = 0, save_hold = 0;
    int p_kind, p_ch, p_ra, p_ma;
    logic [31:0] p_d;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int obs_kind();
        if (reg_req) return reg_we ? 0 : 1;
        return mem_we ? 3 : 2;
    endfunction

    function automatic logic [31:0] obs_data();
        if (reg_req) return reg_wdata;
        return {24'h0, mem_wdata};
    endfunction

    // responder and per-clock reference comparison
    always @(negedge clk) begin
        if (rst) begin
            reg_ack = 0; mem_ack = 0; wait_cnt = 0; pend = 0;
            prev_stream = 0; settle_cnt = 0;
        end else begin
            // R6: one port at a time
            chk(!(reg_req && mem_req), "R6", "both ports requesting", {31'h0, mem_req}, 0);
            // R7 / R11: stream enable timing and stickiness
            if (status == 3'd3) settle_cnt++;
            else if (status == 3'd1) settle_cnt = 0;
            if (stream_en && !prev_stream) begin
                chk(settle_cnt == 255, "R7", "settle length", settle_cnt, 255);
                chk(status == 3'd4, "R10", "status at stream start", {29'h0, status}, 4);
            end
            if (prev_stream) chk(stream_en, "R11", "stream_en dropped", {31'h0, stream_en}, 1);
            prev_stream = stream_en;
            if (save_hold) chk(status != 3'd5, "R9", "save started while loading", {29'h0, status}, 0);

            if (reg_ack || mem_ack) begin
                reg_ack = 0; mem_ack = 0;
                chk(!reg_req && !mem_req, "R6", "request right after ack",
                    {30'h0, reg_req, mem_req}, 0);
            end else if (reg_req || mem_req) begin
                if (pend) begin
                    chk(obs_kind() == p_kind && int'(reg_ch) == p_ch && int'(reg_addr) == p_ra
                        && int'(mem_addr) == p_ma && obs_data() == p_d,
                        "R6", "fields changed while pending", obs_data(), p_d);
                end
                pend = 1; p_kind = obs_kind(); p_ch = int'(reg_ch); p_ra = int'(reg_addr);
                p_ma = int'(mem_addr); p_d = obs_data();
                if (wait_cnt < ntx % 3) wait_cnt++;
                else begin
                    txn_t e;
                    int k;
                    k = obs_kind();
                    wait_cnt = 0; pend = 0; ntx++;
                    if (expq.size() == 0) begin
                        chk(0, "R4", "unexpected access kind", k, 32'hFFFFFFFF);
                    end else begin
                        e = expq.pop_front();
                        chk(k == e.kind, e.tag, "access kind", k, e.kind);
                        if (k < 2) begin
                            chk(int'(reg_ch) == e.ch && int'(reg_addr) == e.ra, e.tag,
                                "channel/register", {reg_ch, 3'b0, reg_addr}, (e.ch << 7) | e.ra);
                            if (k == 0) chk(reg_wdata == e.d, e.tag, "register data", reg_wdata, e.d);
                        end else begin
                            chk(int'(mem_addr) == e.ma, e.tag, "byte address", mem_addr, e.ma);
                            if (k == 3) chk(mem_wdata == e.d[7:0], e.tag, "byte data", mem_wdata, e.d);
                        end
                    end
                    case (k)
                        0: rf[int'(reg_ch) * 11 + int'(reg_addr)] = reg_wdata;
                        1: reg_rdata = rf[int'(reg_ch) * 11 + int'(reg_addr)];
                        2: mem_rdata = mem[mem_addr];
                        default: mem[mem_addr] = mem_wdata;
                    endcase
                    if (k < 2) reg_ack = 1; else mem_ack = 1;
                end
            end
        end
    end

    task automatic push(input int kind, input int ch, input int ra, input int ma,
                        input logic [31:0] d, input string tag);
        txn_t t;
        t.kind = kind; t.ch = ch; t.ra = ra; t.ma = ma; t.d = d; t.tag = tag;
        expq.push_back(t);
    endtask

    task automatic exp_defaults();
        for (int w = 0; w < 22; w++) push(0, w / 11, w % 11, 0, DEF[w], "R2");
    endtask

    task automatic exp_header();
        for (int b = 0; b < 4; b++) push(2, 0, 0, 16'h3F00 + b, 0, "R3");
    endtask

    function automatic logic [31:0] img_word(input int w);
        int a;
        a = 16'h3F04 + 4 * w;
        return {mem[a + 3], mem[a + 2], mem[a + 1], mem[a]};
    endfunction

    task automatic exp_stored();
        for (int w = 0; w < 22; w++) begin
            for (int b = 0; b < 4; b++) push(2, 0, 0, 16'h3F04 + 4 * w + b, 0, "R5");
            push(0, w / 11, w % 11, 0, img_word(w), "R5");
        end
    endtask

    task automatic exp_save();
        for (int b = 0; b < 4; b++) push(3, 0, 0, 16'h3F00 + b, {24'h0, MAGIC[8*b +: 8]}, "R8");
        for (int w = 0; w < 22; w++) begin
            push(1, w / 11, w % 11, 0, 0, "R8");
            for (int b = 0; b < 4; b++)
                push(3, 0, 0, 16'h3F04 + 4 * w + b, {24'h0, rf[w][8*b +: 8]}, "R8");
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(status == 3'd0 && !stream_en && !reg_req && !mem_req, "R1", "reset state",
            {27'h0, status, stream_en, reg_req | mem_req}, 0);
        rst = 0;
        @(negedge clk);
        chk(status == 3'd1, "R1", "status after reset release", {29'h0, status}, 1);
    endtask

    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (!(status == 3'd4 && expq.size() == 0 && !reg_req && !mem_req) && n < 20000) begin
            @(negedge clk);
            if (status == 3'd4) save_hold = 0;
            n++;
        end
        repeat (5) @(negedge clk);
        chk(expq.size() == 0, tag, "pending expected accesses", expq.size(), 0);
        chk(status == 3'd4 && stream_en, tag, "done with stream", {28'h0, status, stream_en}, 9);
    endtask

    task automatic chk_rf(input string tag, input bit use_def, input logic [31:0] alt [22]);
        for (int w = 0; w < 22; w++)
            chk(rf[w] == (use_def ? DEF[w] : alt[w]), tag, "register contents", rf[w],
                use_def ? DEF[w] : alt[w]);
    endtask

    initial begin
        logic [31:0] stored [22];
        for (int a = 0; a < 16384; a++) mem[a] = 8'h00;
        for (int w = 0; w < 22; w++) rf[w] = 32'h0;
        for (int w = 0; w < 22; w++) stored[w] = 32'hC0DE0000 ^ (w * 32'h01030507);

        // blank memory: header mismatch, factory values stay (R2, R3, R4)
        exp_defaults(); exp_header();
        do_reset();
        wait_done("R4");
        chk_rf("R4", 1, stored);

        // save from done state (R8, R10, R11)
        exp_save();
        @(negedge clk); save_req = 1;
        @(negedge clk); save_req = 0;
        chk(status == 3'd5, "R10", "status while saving", {29'h0, status}, 5);
        repeat (30) @(negedge clk);
        save_req = 1;                      // R9: pulse during saving
        @(negedge clk); save_req = 0;
        wait_done("R8");
        for (int b = 0; b < 4; b++)
            chk(mem[16'h3F00 + b] == MAGIC[8*b +: 8], "R8", "stored header byte",
                mem[16'h3F00 + b], MAGIC[8*b +: 8]);
        for (int w = 0; w < 22; w++)
            chk(img_word(w) == DEF[w], "R8", "stored image word", img_word(w), DEF[w]);

        // valid header, distinct stored words, save held during loading (R5, R9)
        for (int w = 0; w < 22; w++)
            for (int b = 0; b < 4; b++) mem[16'h3F04 + 4 * w + b] = stored[w][8*b +: 8];
        exp_defaults(); exp_header(); exp_stored();
        save_hold = 1; save_req = 1;
        do_reset();
        while (status != 3'd4) @(negedge clk);
        save_req = 0; save_hold = 0;
        wait_done("R9");
        chk_rf("R5", 0, stored);

        // header bytes in reversed order: mismatch (R3, R4)
        mem[16'h3F00] = 8'hAB; mem[16'h3F01] = 8'hC0; mem[16'h3F02] = 8'h0C; mem[16'h3F03] = 8'hBA;
        exp_defaults(); exp_header();
        do_reset();
        wait_done("R3");
        chk_rf("R4", 1, stored);

        // one wrong top byte: mismatch (R4)
        for (int b = 0; b < 4; b++) mem[16'h3F00 + b] = MAGIC[8*b +: 8];
        mem[16'h3F03] = 8'hAA;
        for (int w = 0; w < 22; w++) rf[w] = 32'h0;
        exp_defaults(); exp_header();
        do_reset();
        wait_done("R4");
        chk_rf("R2", 1, stored);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R6 watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule